// File: doc/BRIEF.md
# Conditional Branch and Link Unit

This block resolves the two control-transfer opcodes of a 32-bit register machine. Each step, the surrounding pipeline presents four things: the fetched instruction word, the values read for its rb and rc operands, and the program counter. The program counter has already been moved past the branch, so it holds the branch address plus 4. The block tests a 3-bit condition in the low bits of the instruction against the rc value. It then decides the next program counter. For the linking form, it also produces a register write that saves the return address.

All results are registered on a step strobe. The held program counter only moves when a step is applied. The take flag and the link write enable are one-cycle pulses in the cycle after the step. All outputs of a step are computed from the operand values sampled at that strobe. A link write therefore never disturbs the branch target, even when the link destination and the target register are the same register. The register file is not part of the block.

Top module: `brl_unit`

## Requirements
- R1: After reset, `pc_o` is `RESET_PC` (default 0), and both `take_o` and `link_we_o` are low.
- R2: The condition code is instruction bits [2:0]. Code 0 is never true and code 1 is always true. Code 2 is true when rc is zero and code 3 when rc is nonzero. Code 4 is true when rc bit 31 is 0 and code 5 when it is 1. Codes 6 and 7 are never true.
- R3: For opcode 8 (instruction bits [31:27]) with a true condition, the cycle after the step shows `take_o` high and `pc_o` equal to the rb value sampled at the step.
- R4: For a branch opcode with a false condition, the cycle after the step shows `take_o` low and `pc_o` equal to `pc_i` sampled at the step.
- R5: For opcode 9, the cycle after the step always shows `link_we_o` high, whatever the condition. `link_idx_o` equals instruction bits [26:22] and `link_data_o` equals the sampled `pc_i`.
- R6: Opcode 9 loads `pc_o` from rb only when the condition is true.
- R7: When the link index equals the rb field (bits [21:17]), the new PC is still the rb value sampled at the step. The link data is the sampled `pc_i`.
- R8: For any opcode other than 8 or 9, the cycle after the step shows `take_o` and `link_we_o` low, and `pc_o` equal to the sampled `pc_i`.
- R9: In a cycle with `step_i` low, `pc_o` keeps its value on the next cycle, and `take_o` and `link_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Applies the presented instruction this cycle |
| instr_i | input | 32 | Instruction word |
| rb_val_i | input | XLEN | Value of the rb operand register |
| rc_val_i | input | XLEN | Value of the rc operand register |
| pc_i | input | XLEN | Program counter already advanced past the branch |
| pc_o | output | XLEN | Held program counter |
| take_o | output | 1 | Branch taken pulse for the last step |
| link_we_o | output | 1 | Link register write enable pulse |
| link_idx_o | output | 5 | Link destination register index |
| link_data_o | output | XLEN | Return address to write |

## Verification
Every result of a step appears exactly one clock edge after the strobe, because each output comes straight from a register. The bench drives inputs on the falling edge and holds `step_i` high for one cycle. It then samples all outputs on the following falling edge, once that single register stage has loaded. A second sample one cycle later, with the strobe low, confirms that the pulses drop and the program counter holds. The sweep covers every condition code against zero, positive, negative and all-ones rc values for both branch opcodes, and every other opcode.

// File: rtl/brl_pkg.sv
package brl_pkg;
    localparam int ILEN    = 32;
    localparam int OPC_W   = 5;
    localparam int IDX_W   = 5;
    localparam int CC_W    = 3;
    localparam int OPC_LSB = ILEN - OPC_W;
    localparam int RA_LSB  = OPC_LSB - IDX_W;

    localparam logic [OPC_W-1:0] OPC_BR  = 5'd8;
    localparam logic [OPC_W-1:0] OPC_BRL = 5'd9;

    typedef enum logic [CC_W-1:0] {
        CC_NEVER   = 3'd0,
        CC_ALWAYS  = 3'd1,
        CC_ZERO    = 3'd2,
        CC_NONZERO = 3'd3,
        CC_NONNEG  = 3'd4,
        CC_NEG     = 3'd5,
        CC_RSV6    = 3'd6,
        CC_RSV7    = 3'd7
    } cc_e;
endpackage

// File: rtl/brl_decode.sv
module brl_decode
    import brl_pkg::*;
(
    input  logic [ILEN-1:0]  instr,
    output logic             is_br,
    output logic             is_brl,
    output logic [IDX_W-1:0] ra_idx,
    output cc_e              cc
);
    logic [OPC_W-1:0] opc;
    logic             unused_bits;

    always_comb begin
        opc    = instr[OPC_LSB +: OPC_W];
        ra_idx = instr[RA_LSB +: IDX_W];
        cc     = cc_e'(instr[CC_W-1:0]);
        is_br  = (opc == OPC_BR);
        is_brl = (opc == OPC_BRL);
    end

    assign unused_bits = ^instr[RA_LSB-1:CC_W];
endmodule

// File: rtl/brl_cond.sv
module brl_cond
    import brl_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cc_e             cc,
    input  logic [XLEN-1:0] rc_val,
    output logic            holds
);
    logic is_zero;
    logic sign;

    always_comb begin
        is_zero = (rc_val == '0);
        sign    = rc_val[XLEN-1];
        unique case (cc)
            CC_ALWAYS:  holds = 1'b1;
            CC_ZERO:    holds = is_zero;
            CC_NONZERO: holds = !is_zero;
            CC_NONNEG:  holds = !sign;
            CC_NEG:     holds = sign;
            default:    holds = 1'b0;
        endcase
    end
endmodule

// File: rtl/brl_unit.sv
module brl_unit
    import brl_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic [ILEN-1:0]  instr_i,
    input  logic [XLEN-1:0]  rb_val_i,
    input  logic [XLEN-1:0]  rc_val_i,
    input  logic [XLEN-1:0]  pc_i,
    output logic [XLEN-1:0]  pc_o,
    output logic             take_o,
    output logic             link_we_o,
    output logic [IDX_W-1:0] link_idx_o,
    output logic [XLEN-1:0]  link_data_o
);
    typedef struct packed {
        logic [XLEN-1:0]  pc;
        logic             take;
        logic             link_we;
        logic [IDX_W-1:0] link_idx;
        logic [XLEN-1:0]  link_data;
    } state_t;

    state_t state_d;
    state_t state_q;

    logic             is_br;
    logic             is_brl;
    logic [IDX_W-1:0] ra_idx;
    cc_e              cc;
    logic             cond_holds;

    brl_decode i_decode (
        .instr  (instr_i),
        .is_br  (is_br),
        .is_brl (is_brl),
        .ra_idx (ra_idx),
        .cc     (cc)
    );

    brl_cond #(.XLEN(XLEN)) i_cond (
        .cc     (cc),
        .rc_val (rc_val_i),
        .holds  (cond_holds)
    );

    always_comb begin
        state_d           = state_q;
        state_d.take      = 1'b0;
        state_d.link_we   = 1'b0;
        if (step_i) begin
            // every right-hand value is taken from this cycle's inputs
            state_d.take      = (is_br || is_brl) && cond_holds;
            state_d.pc        = state_d.take ? rb_val_i : pc_i;
            state_d.link_we   = is_brl;
            state_d.link_idx  = ra_idx;
            state_d.link_data = pc_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.pc        <= RESET_PC;
            state_q.take      <= 1'b0;
            state_q.link_we   <= 1'b0;
            state_q.link_idx  <= '0;
            state_q.link_data <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc_o        = state_q.pc;
    assign take_o      = state_q.take;
    assign link_we_o   = state_q.link_we;
    assign link_idx_o  = state_q.link_idx;
    assign link_data_o = state_q.link_data;
endmodule

// File: rtl/brl_unit_chk.sv
module brl_unit_chk
    import brl_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_i,
    input logic [ILEN-1:0]  instr_i,
    input logic [XLEN-1:0]  rb_val_i,
    input logic [XLEN-1:0]  pc_i,
    input logic [XLEN-1:0]  pc_o,
    input logic             take_o,
    input logic             link_we_o,
    input logic [IDX_W-1:0] link_idx_o,
    input logic [XLEN-1:0]  link_data_o
);
    logic [OPC_W-1:0] opc;
    assign opc = instr_i[OPC_LSB +: OPC_W];

    AST_NEVER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && instr_i[2:0] == 3'd0) |=> !take_o); // R2
    AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (!take_o || pc_o == $past(rb_val_i))); // R3
    AST_FALLTHRU_PC: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (take_o || pc_o == $past(pc_i))); // R4
    AST_LINK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && opc == OPC_BRL) |=> (link_we_o && link_data_o == $past(pc_i)
            && link_idx_o == $past(instr_i[RA_LSB +: IDX_W]))); // R5
    AST_OTHER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && opc != OPC_BR && opc != OPC_BRL) |=> (!take_o && !link_we_o)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> ($stable(pc_o) && !take_o && !link_we_o)); // R9
endmodule

bind brl_unit brl_unit_chk #(.XLEN(XLEN)) i_brl_unit_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (step_i),
    .instr_i     (instr_i),
    .rb_val_i    (rb_val_i),
    .pc_i        (pc_i),
    .pc_o        (pc_o),
    .take_o      (take_o),
    .link_we_o   (link_we_o),
    .link_idx_o  (link_idx_o),
    .link_data_o (link_data_o)
);

// File: tb/test_brl_unit.sv
module test_brl_unit;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            step_i = 1'b0;
    logic [31:0]     instr_i = '0;
    logic [XLEN-1:0] rb_val_i = '0;
    logic [XLEN-1:0] rc_val_i = '0;
    logic [XLEN-1:0] pc_i = '0;
    logic [XLEN-1:0] pc_o;
    logic            take_o;
    logic            link_we_o;
    logic [4:0]      link_idx_o;
    logic [XLEN-1:0] link_data_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    brl_unit #(.XLEN(XLEN)) i_brl_unit (
        .clk, .rst_n, .step_i, .instr_i, .rb_val_i, .rc_val_i, .pc_i,
        .pc_o, .take_o, .link_we_o, .link_idx_o, .link_data_o
    );

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R2 table written from the requirement
    function automatic bit cond_ref(input int cc, input logic [31:0] rc);
        case (cc)
            1: return 1'b1;
            2: return rc == 0;
            3: return rc != 0;
            4: return rc[31] == 1'b0;
            5: return rc[31] == 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic apply(input int op, input int ra, input int rb, input int cc,
                         input logic [31:0] rbv, input logic [31:0] rcv, input logic [31:0] pc);
        bit isb;
        bit tk;
        logic [31:0] prev_pc;
        @(negedge clk);
        instr_i  = {op[4:0], ra[4:0], rb[4:0], 14'h1a5, cc[2:0]};
        rb_val_i = rbv;
        rc_val_i = rcv;
        pc_i     = pc;
        step_i   = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
        isb = (op == 8) || (op == 9);
        tk  = isb && cond_ref(cc, rcv);
        if (isb) chk("R2 take", {31'b0, take_o}, {31'b0, tk});
        else     chk("R8 take", {31'b0, take_o}, 32'd0);
        if (tk)       chk(op == 8 ? "R3 pc" : "R6 pc", pc_o, rbv);
        else if (isb) chk("R4 pc", pc_o, pc);
        else          chk("R8 pc", pc_o, pc);
        if (op == 9) begin
            chk("R5 we", {31'b0, link_we_o}, 32'd1);
            chk("R5 idx", {27'b0, link_idx_o}, ra);
            chk("R5 data", link_data_o, pc);
        end else begin
            chk(isb ? "R3 we" : "R8 we", {31'b0, link_we_o}, 32'd0);
        end
        prev_pc = pc_o;
        instr_i  = ~instr_i;
        rb_val_i = ~rbv;
        pc_i     = ~pc;
        @(negedge clk);
        chk("R9 pc", pc_o, prev_pc);
        chk("R9 take", {31'b0, take_o}, 32'd0);
        chk("R9 we", {31'b0, link_we_o}, 32'd0);
    endtask

    initial begin
        logic [31:0] rcs [5];
        int k = 0;
        rcs[0] = 32'h0; rcs[1] = 32'h1; rcs[2] = 32'h8000_0000;
        rcs[3] = 32'h7fff_ffff; rcs[4] = 32'hffff_ffff;
        repeat (3) @(negedge clk);
        chk("R1 pc", pc_o, 32'h0);
        chk("R1 take", {31'b0, take_o}, 32'd0);
        chk("R1 we", {31'b0, link_we_o}, 32'd0);
        rst_n = 1'b1;
        for (int op = 8; op <= 9; op++)
            for (int cc = 0; cc < 8; cc++)
                for (int r = 0; r < 5; r++) begin
                    k++;
                    apply(op, (k * 7) % 32, (k * 3) % 32, cc,
                          32'hc000_0000 ^ (k << 4), rcs[r], 32'h1000 + 4 * k);
                end
        for (int op = 0; op < 32; op++)
            if (op != 8 && op != 9)
                apply(op, 3, 4, 1, 32'h0bad_0000 + op, 32'h0, 32'h2000 + 4 * op);
        // R7: link destination equals target register
        apply(9, 6, 6, 1, 32'h0000_5550, 32'h0, 32'h0000_3004);
        apply(9, 17, 17, 2, 32'h0000_7770, 32'h0, 32'h0000_4008);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule